// File: doc/BRIEF.md
# Off-Prime False-Trigger Filter

This block sits behind a trigger array that fires on a superset of the conditions the user asked for. Each time the array fires, the block opens a trace segment and gives it an identifier. At the same moment it stores the trigger-signal value, with that identifier, in a small event buffer. A scanner takes the buffered values one at a time. It walks a table of off-prime cubes, one entry per clock. A cube is a mask/value pair that was worked out before the run and written into the block.

If any cube in the active part of the table covers the captured value, the trigger was spurious. The segment is then reported as reclaimable. Otherwise the segment is reported as holding a genuine trigger. Each verdict comes out on a one-cycle strobe together with the segment identifier. When triggers arrive faster than the scanner can process them, the buffer fills. Any further trigger is discarded, and a sticky overflow flag records the loss until it is cleared.

Top module: `trig_false_filter`

## Requirements
- R1: After reset, `verdictStb` and `ovfSticky` are 0 and `segOpenId` is 0.
- R2: A cube covers a value when, at every bit where its mask is 1, the value equals the cube's value bit. Bits with mask 0 are ignored.
- R3: Cubes are examined one per clock, in index order from 0 up to the active length minus one. With the scanner idle and active length L, the verdict strobe rises max(L,1)+1 clock edges after the edge that accepted the trigger.
- R4: The verdict is false (`verdictFalse`=1) when any of the first `listLen` cubes covers the value. Cubes at or above `listLen` have no effect. A `listLen` above the table size counts as the table size.
- R5: The verdict is valid (`verdictFalse`=0) when no active cube covers the value, and always when `listLen` is 0.
- R6: An accepted trigger raises `segOpen` in the same cycle, and `segOpenId` shows the identifier it receives. Identifiers go round-robin 0..NUM_SEGS-1 over accepted triggers only.
- R7: Each verdict is a single-cycle `verdictStb` pulse carrying `verdictId` equal to the segment's identifier. Verdicts come out in trigger order.
- R8: The event buffer holds BUF_DEPTH entries (default 2). An entry is loaded into the scanner on the edge after the previous verdict, or on the edge after the entry was pushed, whichever is later.
- R9: A trigger that arrives while the buffer is full, with no entry leaving on that edge, is dropped. It raises no `segOpen`, consumes no identifier and produces no verdict, and `ovfSticky` reads 1 from the next cycle.
- R10: `ovfClr` clears `ovfSticky` on the next edge, so it reads 0. A drop on the same edge takes priority and leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 1 | Trigger from the trigger array |
| trigVal | input | SIG_W | Trigger-signal value at the trigger |
| cubeWe | input | 1 | Write strobe for the cube table |
| cubeWrIdx | input | IDX_W | Cube table entry to write |
| cubeWrMask | input | SIG_W | Mask of the cube (1 = bit compared) |
| cubeWrValue | input | SIG_W | Value of the cube |
| listLen | input | LEN_W | Number of active cubes, starting at entry 0 |
| ovfClr | input | 1 | Clears the overflow flag |
| segOpen | output | 1 | A trace segment opens this cycle |
| segOpenId | output | SEG_W | Identifier of the segment that opens |
| verdictStb | output | 1 | Verdict strobe, one cycle |
| verdictId | output | SEG_W | Segment identifier the verdict refers to |
| verdictFalse | output | 1 | 1 = false trigger (reclaimable), 0 = genuine |
| ovfSticky | output | 1 | Sticky flag: a trigger was lost |

## Verification
`segOpen` and `segOpenId` are combinational, so they are checked 1 ns after the inputs are driven, in the same cycle. `ovfSticky` is checked at the falling edge after the clock edge that set or cleared it.

For each accepted trigger, the bench computes the edge on which the scanner loads it: one edge after the push, or one edge after the previous verdict, whichever is later. The verdict is due max(L,1) edges after that load edge. The bench samples at the falling edge after that clock edge. At every other falling edge it requires `verdictStb` to be low, so a late or early strobe fails in the cycle it happens.

// File: rtl/trig_filt_pkg.sv
package trig_filt_pkg;

  typedef struct packed {
    logic push;    // accepted trigger written into the event buffer
    logic load;    // head of the event buffer moves into the scanner
    logic finish;  // last cube compared, verdict is registered
  } filtStb_t;

endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import trig_filt_pkg::*;
#(
  parameter int NUM_CUBES = 4,
  parameter int BUF_DEPTH = 2,
  parameter int IDX_W     = 2,
  parameter int LEN_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [LEN_W-1:0] listLen,
  input  logic             ovfClr,
  input  logic             cubeHit,
  output filtStb_t         stb,
  output logic [IDX_W-1:0] scanIdx,
  output logic             verdictStb,
  output logic             verdictFalse,
  output logic             ovfSticky
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic             hitAcc;

  logic [LEN_W-1:0] effLen;
  logic             inWindow;
  logic             lastStep;
  logic             hitNow;
  logic             accept;

  // clamp the active length to the table size
  always_comb begin
    if (listLen > LEN_W'(NUM_CUBES)) effLen = LEN_W'(NUM_CUBES);
    else                             effLen = listLen;
  end

  assign inWindow = LEN_W'(idx) < effLen;
  assign lastStep = (LEN_W'(idx) + LEN_W'(1)) >= effLen;
  assign hitNow   = cubeHit && inWindow;

  assign stb.load   = !busy && (count != '0);
  assign accept     = (count < CNT_W'(BUF_DEPTH)) || stb.load;
  assign stb.push   = trigIn && accept;
  assign stb.finish = busy && lastStep;
  assign scanIdx    = idx;

  // event buffer occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.push && !stb.load) begin
      count <= count + CNT_W'(1);
    end else if (!stb.push && stb.load) begin
      count <= count - CNT_W'(1);
    end
  end

  // sequential scanner: one cube per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      idx    <= '0;
      hitAcc <= 1'b0;
    end else if (stb.load) begin
      busy   <= 1'b1;
      idx    <= '0;
      hitAcc <= 1'b0;
    end else if (busy) begin
      hitAcc <= hitAcc | hitNow;
      if (lastStep) busy <= 1'b0;
      else          idx  <= idx + IDX_W'(1);
    end
  end

  // registered verdict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictStb   <= 1'b0;
      verdictFalse <= 1'b0;
    end else begin
      verdictStb <= stb.finish;
      if (stb.finish) verdictFalse <= hitAcc | hitNow;
    end
  end

  // sticky overflow: a drop takes priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovfSticky <= 1'b0;
    else if (trigIn && !accept) ovfSticky <= 1'b1;
    else if (ovfClr)            ovfSticky <= 1'b0;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(BUF_DEPTH)); // R8

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && !accept) |=> ovfSticky); // R9

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !(trigIn && !accept)) |=> !ovfSticky); // R10

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    verdictStb |=> !verdictStb); // R7

  AST_SCAN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && effLen != '0) |-> inWindow); // R3

endmodule

// File: rtl/tf_datapath.sv
module tf_datapath
  import trig_filt_pkg::*;
#(
  parameter int SIG_W     = 8,
  parameter int NUM_CUBES = 4,
  parameter int BUF_DEPTH = 2,
  parameter int NUM_SEGS  = 4,
  parameter int IDX_W     = 2,
  parameter int SEG_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  filtStb_t         stb,
  input  logic [IDX_W-1:0] scanIdx,
  input  logic [SIG_W-1:0] trigVal,
  input  logic             cubeWe,
  input  logic [IDX_W-1:0] cubeWrIdx,
  input  logic [SIG_W-1:0] cubeWrMask,
  input  logic [SIG_W-1:0] cubeWrValue,
  output logic             cubeHit,
  output logic [SEG_W-1:0] nextId,
  output logic [SEG_W-1:0] verdictId
);

  localparam int PTR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  logic [SIG_W-1:0] maskArr [NUM_CUBES];
  logic [SIG_W-1:0] valArr  [NUM_CUBES];

  logic [SIG_W-1:0] bufVal [BUF_DEPTH];
  logic [SEG_W-1:0] bufId  [BUF_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  logic [SIG_W-1:0] scanVal;
  logic [SEG_W-1:0] scanId;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // off-prime cube table, one register pair per entry
  for (genvar g = 0; g < NUM_CUBES; g++) begin : gCube
    logic [SIG_W-1:0] maskQ, valQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ <= '0;
        valQ  <= '0;
      end else if (cubeWe && cubeWrIdx == IDX_W'(g)) begin
        maskQ <= cubeWrMask;
        valQ  <= cubeWrValue;
      end
    end
    assign maskArr[g] = maskQ;
    assign valArr[g]  = valQ;
  end

  // compare the scanned value against the current cube
  assign cubeHit = ((scanVal ^ valArr[scanIdx]) & maskArr[scanIdx]) == '0;

  // event buffer storage
  for (genvar b = 0; b < BUF_DEPTH; b++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufVal[b] <= '0;
        bufId[b]  <= '0;
      end else if (stb.push && wrPtr == PTR_W'(b)) begin
        bufVal[b] <= trigVal;
        bufId[b]  <= nextId;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      nextId    <= '0;
      scanVal   <= '0;
      scanId    <= '0;
      verdictId <= '0;
    end else begin
      if (stb.push) begin
        wrPtr  <= ptrNext(wrPtr);
        nextId <= (nextId == SEG_W'(NUM_SEGS - 1)) ? '0 : nextId + SEG_W'(1);
      end
      if (stb.load) begin
        rdPtr   <= ptrNext(rdPtr);
        scanVal <= bufVal[rdPtr];
        scanId  <= bufId[rdPtr];
      end
      if (stb.finish) verdictId <= scanId;
    end
  end

  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.push |=> $stable(nextId)); // R9

  AST_ID_CHANGES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && NUM_SEGS > 1) |=> !$stable(nextId)); // R6

endmodule

// File: rtl/trig_false_filter.sv
module trig_false_filter
  import trig_filt_pkg::*;
#(
  parameter int SIG_W     = 8,
  parameter int NUM_CUBES = 4,
  parameter int BUF_DEPTH = 2,
  parameter int NUM_SEGS  = 4,
  localparam int IDX_W    = (NUM_CUBES > 1) ? $clog2(NUM_CUBES) : 1,
  localparam int LEN_W    = $clog2(NUM_CUBES + 1),
  localparam int SEG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [SIG_W-1:0] trigVal,
  input  logic             cubeWe,
  input  logic [IDX_W-1:0] cubeWrIdx,
  input  logic [SIG_W-1:0] cubeWrMask,
  input  logic [SIG_W-1:0] cubeWrValue,
  input  logic [LEN_W-1:0] listLen,
  input  logic             ovfClr,
  output logic             segOpen,
  output logic [SEG_W-1:0] segOpenId,
  output logic             verdictStb,
  output logic [SEG_W-1:0] verdictId,
  output logic             verdictFalse,
  output logic             ovfSticky
);

  filtStb_t         stb;
  logic [IDX_W-1:0] scanIdx;
  logic             cubeHit;
  logic [SEG_W-1:0] nextId;

  tf_ctrl #(
    .NUM_CUBES (NUM_CUBES),
    .BUF_DEPTH (BUF_DEPTH),
    .IDX_W     (IDX_W),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .trigIn       (trigIn),
    .listLen      (listLen),
    .ovfClr       (ovfClr),
    .cubeHit      (cubeHit),
    .stb          (stb),
    .scanIdx      (scanIdx),
    .verdictStb   (verdictStb),
    .verdictFalse (verdictFalse),
    .ovfSticky    (ovfSticky)
  );

  tf_datapath #(
    .SIG_W     (SIG_W),
    .NUM_CUBES (NUM_CUBES),
    .BUF_DEPTH (BUF_DEPTH),
    .NUM_SEGS  (NUM_SEGS),
    .IDX_W     (IDX_W),
    .SEG_W     (SEG_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .scanIdx     (scanIdx),
    .trigVal     (trigVal),
    .cubeWe      (cubeWe),
    .cubeWrIdx   (cubeWrIdx),
    .cubeWrMask  (cubeWrMask),
    .cubeWrValue (cubeWrValue),
    .cubeHit     (cubeHit),
    .nextId      (nextId),
    .verdictId   (verdictId)
  );

  assign segOpen   = stb.push;
  assign segOpenId = nextId;

  AST_OPEN_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    segOpen |-> trigIn); // R6

endmodule

// File: tb/test_trig_false_filter.sv
module test_trig_false_filter;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SIG_W = 8;
  localparam int NC    = 4;
  localparam int BD    = 2;
  localparam int NS    = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigIn = 1'b0;
  logic [7:0] trigVal = '0;
  logic       cubeWe = 1'b0;
  logic [1:0] cubeWrIdx = '0;
  logic [7:0] cubeWrMask = '0;
  logic [7:0] cubeWrValue = '0;
  logic [2:0] listLen = '0;
  logic       ovfClr = 1'b0;
  logic       segOpen;
  logic [1:0] segOpenId;
  logic       verdictStb;
  logic [1:0] verdictId;
  logic       verdictFalse;
  logic       ovfSticky;

  trig_false_filter #(.SIG_W(SIG_W), .NUM_CUBES(NC), .BUF_DEPTH(BD), .NUM_SEGS(NS))
    i_trig_false_filter (
      .clk(clk), .rstN(rstN), .trigIn(trigIn), .trigVal(trigVal),
      .cubeWe(cubeWe), .cubeWrIdx(cubeWrIdx), .cubeWrMask(cubeWrMask),
      .cubeWrValue(cubeWrValue), .listLen(listLen), .ovfClr(ovfClr),
      .segOpen(segOpen), .segOpenId(segOpenId), .verdictStb(verdictStb),
      .verdictId(verdictId), .verdictFalse(verdictFalse), .ovfSticky(ovfSticky));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench-side model state
  logic [7:0] bm [NC];
  logic [7:0] bv [NC];
  int  lenDrv  = 0;
  int  nextIdM = 0;
  int  lastDue = -100;
  bit  ovfM    = 1'b0;
  int  loadQ[$];
  int  qDue[$];
  int  qId[$];
  int  qFls[$];
  bit  wWe = 1'b0;
  logic [1:0] wIdx;
  logic [7:0] wMask, wVal;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit benchFalse(logic [7:0] val, int len);
    int l = (len > NC) ? NC : len;
    for (int i = 0; i < l; i++)
      if (((val ^ bv[i]) & bm[i]) == 8'h00) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(bit trig, logic [7:0] val, bit clr);
    int e, cnt, ld, d, lEff;
    bit popping, acc;
    @(negedge clk);
    // results of the edge numbered cyc
    while (qDue.size() > 0 && qDue[0] < cyc) begin
      chk(1'b0, "R3", "verdict missed at due edge", 0, 1);
      void'(qDue.pop_front()); void'(qId.pop_front()); void'(qFls.pop_front());
    end
    if (qDue.size() > 0 && qDue[0] == cyc) begin
      chk(verdictStb == 1'b1, "R3", "verdict strobe at due edge", int'(verdictStb), 1);
      chk(verdictId == 2'(qId[0]), "R7", "verdict id", int'(verdictId), qId[0]);
      chk(verdictFalse == qFls[0][0], qFls[0] != 0 ? "R4" : "R5", "verdict false flag",
          int'(verdictFalse), qFls[0]);
      void'(qDue.pop_front()); void'(qId.pop_front()); void'(qFls.pop_front());
    end else begin
      chk(verdictStb == 1'b0, "R7", "strobe outside due edge", int'(verdictStb), 0);
    end
    chk(ovfSticky == ovfM, ovfM ? "R9" : "R10", "overflow flag", int'(ovfSticky), int'(ovfM));
    // drive for the next edge
    trigIn = trig; trigVal = val; ovfClr = clr; listLen = 3'(lenDrv);
    cubeWe = wWe; cubeWrIdx = wIdx; cubeWrMask = wMask; cubeWrValue = wVal;
    #1;
    e = cyc + 1;
    while (loadQ.size() > 0 && loadQ[0] < e) void'(loadQ.pop_front());
    cnt = loadQ.size();
    popping = (cnt > 0) && (loadQ[0] == e);
    acc = trig && ((cnt < BD) || popping);
    chk(segOpen == acc, acc ? "R6" : "R9", "segment open", int'(segOpen), int'(acc));
    if (acc) begin
      chk(segOpenId == 2'(nextIdM), "R6", "segment id", int'(segOpenId), nextIdM);
      lEff = (lenDrv > NC) ? NC : lenDrv;
      ld = (e + 1 > lastDue + 1) ? e + 1 : lastDue + 1;
      d  = ld + ((lEff > 1) ? lEff : 1);
      loadQ.push_back(ld);
      qDue.push_back(d);
      qId.push_back(nextIdM);
      qFls.push_back(int'(benchFalse(val, lenDrv)));
      lastDue = d;
      nextIdM = (nextIdM + 1) % NS;
    end
    if (trig && !acc) ovfM = 1'b1;
    else if (clr)     ovfM = 1'b0;
    wWe = 1'b0;
  endtask

  task automatic writeCube(int idx, logic [7:0] m, logic [7:0] v);
    wWe = 1'b1; wIdx = 2'(idx); wMask = m; wVal = v;
    bm[idx] = m; bv[idx] = v;
    step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic drain();
    while (qDue.size() > 0) step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic oneTrig(int len, logic [7:0] val);
    lenDrv = len;
    step(1'b0, 8'h00, 1'b0);
    step(1'b1, val, 1'b0);
    drain();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin bm[i] = '0; bv[i] = '0; end
    wIdx = '0; wMask = '0; wVal = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(verdictStb == 1'b0, "R1", "strobe in reset", int'(verdictStb), 0);
    chk(ovfSticky == 1'b0, "R1", "overflow in reset", int'(ovfSticky), 0);
    chk(segOpenId == 2'd0, "R1", "first id in reset", int'(segOpenId), 0);
    rstN = 1'b1;

    // directed table; R2 compare only masked bits
    writeCube(0, 8'hF0, 8'hA0);
    writeCube(1, 8'h0F, 8'h05);
    writeCube(2, 8'hFF, 8'h3C);
    writeCube(3, 8'h00, 8'h00);
    oneTrig(2, 8'hA7);   // R2 covered by entry 0 -> false
    oneTrig(2, 8'h15);   // R2 covered by entry 1 -> false
    oneTrig(2, 8'h3C);   // R4 entry 2 outside the window -> valid
    oneTrig(3, 8'h3C);   // R4 entry 2 active -> false
    oneTrig(0, 8'hFF);   // R5 empty list -> valid
    oneTrig(7, 8'h11);   // R4 length clamped, entry 3 covers all -> false
    oneTrig(3, 8'h11);   // R5 nothing covers -> valid
    oneTrig(1, 8'h5A);   // R3 single cube latency

    // R8 R9: burst overflows the buffer
    lenDrv = 4;
    step(1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h40 + i), 1'b0);
    // R10: clear together with a drop keeps the flag set
    step(1'b1, 8'h77, 1'b1);
    drain();
    step(1'b0, 8'h00, 1'b1);   // R10 clear alone
    step(1'b0, 8'h00, 1'b0);
    drain();

    // constrained random phases
    for (int ph = 0; ph < 12; ph++) begin
      for (int i = 0; i < NC; i++) begin
        logic [7:0] m = 8'($urandom) | 8'($urandom);
        writeCube(i, m, 8'($urandom));
      end
      lenDrv = int'($urandom % 6);
      step(1'b0, 8'h00, 1'b0);
      begin
        int rate = 1 + int'($urandom % 5);
        for (int s = 0; s < 300; s++) begin
          bit t = ($urandom % rate) == 0;
          logic [7:0] v;
          if ($urandom % 2 == 0) begin
            int k = int'($urandom % NC);
            v = bv[k] ^ (8'($urandom) & ~bm[k]);
          end else begin
            v = 8'($urandom);
          end
          step(t, v, ($urandom % 25) == 0);
        end
      end
      drain();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule